// File: doc/BRIEF.md
# Serial SRAM Target with Hold

This block is the device side of a four-wire serial memory link. It contains a byte-wide memory array. An external controller drives chip select (active low), a serial clock and a serial data input. The block answers on a serial data output and drives an enable for that output, so that the output pad can be tri-stated. The controller first shifts in an 8-bit opcode. For a memory access, a 16-bit address follows, and then data bytes flow in (write) or out (read) until chip select rises. A mode register decides how the byte pointer moves between bytes: a single byte only, cycling within an aligned page, or running across the whole array.

A pause input lets a controller that shares the serial clock stop a transfer part-way through and resume it later at the same bit. The serial clock is not used as a clock. The block samples it, together with every other link input, on a faster system clock. Each link input passes through a two-flop synchroniser, and edge detection on the synchronised serial clock drives all shifting. Each serial clock phase must therefore last at least three system clocks.

Top module: `spi_sram_target`

## Requirements
- R1: `so_oe` is high only while chip select is low, no pause is active or pending, and the block is in the data phase of a read or a status read. Otherwise it is low, including whenever chip select is high.
- R2: Every field is shifted most significant bit first. Opcode 0x03 reads memory, 0x02 writes memory, 0x05 reads the mode register and 0x01 writes it. Any other opcode makes the block ignore SI and keep `so_oe` low until chip select rises.
- R3: After a memory opcode, 16 address bits follow. Only the low `ADDR_W` bits select the byte and the upper bits are ignored.
- R4: In burst mode the pointer advances by one after every data byte and wraps from the last address to address 0.
- R5: In page mode only the low `PAGE_W` pointer bits advance after every data byte, wrapping from the page's last byte to its first byte. The upper bits stay fixed.
- R6: In single-byte mode only the first data byte of a transfer is stored or returned. Later write bytes are dropped, and later read clocks drive SO to 0.
- R7: Mode register layout:
  - Bits [7:6] select the mode: 00 single byte, 10 page, 01 burst, 11 reserved and treated as single byte.
  - Bit 0 set to 1 disables pausing.
  - Bits [5:1] always read as 0.
  - The register resets to 0x00.
  - A write takes effect only after all 8 bits have arrived. A status read returns the register.
- R8: Chip select rising ends any transfer and returns the block to waiting for an opcode. A write byte that is cut short is not stored.
- R9: With pausing enabled, `hold_n` low starts a pause only while SCK is low. If `hold_n` falls while SCK is high, the pause starts at the next SCK fall. Release is likewise taken only while SCK is low. During a pause, SCK and SI are ignored and `so_oe` is low. After release, the transfer continues from the bit where it stopped.
- R10: With mode register bit 0 set, `hold_n` has no effect on the transfer or on `so_oe`.
- R11: SI is taken on SCK rising edges. SO changes only after SCK falling edges, so it is stable when sampled just before the next rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the controller |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for the SO pad, high to drive |

## Verification
The bench builds the block with `ADDR_W=7` and `PAGE_W=3`, which gives a 128-byte array split into 8-byte pages. With this size, one burst transfer sweeps every address and crosses the top-to-zero wrap, and one page transfer loops a page more than once. The full array contents are compared against a model that the bench keeps by arithmetic. Pauses are placed in the middle of read and write bytes with SCK and SI toggling during the pause, and the pause-disabled case is exercised as well. Address top bits, reserved register bits, aborted bytes and unknown opcodes are all covered at these sizes.

// File: rtl/spi_sram_target.sv
module spi_sram_target #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {P_CMD, P_ADR, P_RD, P_WR, P_SRD, P_SWR, P_IGN} phase_t;

  logic [1:0] cs_q, si_q, hd_q;
  logic [2:0] sck_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 2'b11; si_q <= '0; hd_q <= 2'b11; sck_q <= '0;
    end else begin
      cs_q <= {cs_q[0], cs_n}; si_q <= {si_q[0], si};
      hd_q <= {hd_q[0], hold_n}; sck_q <= {sck_q[1:0], sck};
    end

  wire cs_s = cs_q[1];
  wire si_s = si_q[1];
  wire hd_s = hd_q[1];
  wire sck_s = sck_q[1];
  wire sck_p = sck_q[2];

  logic [7:0] status, sh;
  logic [3:0] cnt;
  logic [ADDR_W-1:0] ptr;
  logic held, done, rdop, so_q;
  phase_t phase;
  logic [7:0] mem [DEPTH];

  wire [1:0] mode = status[7:6];
  wire hold_en = ~status[0];
  wire go = ~cs_s & ~held;
  wire rise = go & sck_s & ~sck_p;
  wire fall = go & ~sck_s & sck_p;
  wire [7:0] nb = {sh[6:0], si_s};
  wire byte_end = (cnt[2:0] == 3'd7);
  wire [7:0] rdata = mem[ptr];

  wire [ADDR_W-1:0] ptr_inc = ptr + 1'b1;
  wire [ADDR_W-1:0] ptr_pg = {ptr[ADDR_W-1:PAGE_W], ptr_inc[PAGE_W-1:0]};
  wire [ADDR_W-1:0] ptr_nx = (mode == 2'b01) ? ptr_inc : (mode == 2'b10) ? ptr_pg : ptr;
  wire single = (mode == 2'b00) | (mode == 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= 1'b0;
    else if (cs_s) held <= 1'b0;
    else if (hold_en & ~hd_s & ~sck_s) held <= 1'b1;
    else if (hd_s & ~sck_s) held <= 1'b0;

  wire wr_en = rise & (phase == P_WR) & byte_end & ~done;
  always_ff @(posedge clk)
    if (wr_en) mem[ptr] <= nb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_CMD; cnt <= '0; sh <= '0; ptr <= '0; status <= '0;
      so_q <= 1'b0; done <= 1'b0; rdop <= 1'b0;
    end else if (cs_s) begin
      phase <= P_CMD; cnt <= '0; done <= 1'b0; so_q <= 1'b0;
    end else begin
      if (rise) begin
        sh <= nb;
        cnt <= cnt + 4'd1;
        case (phase)
          P_CMD: if (cnt == 4'd7) begin
            cnt <= '0;
            case (nb)
              8'h03: begin phase <= P_ADR; rdop <= 1'b1; end
              8'h02: begin phase <= P_ADR; rdop <= 1'b0; end
              8'h05: phase <= P_SRD;
              8'h01: phase <= P_SWR;
              default: phase <= P_IGN;
            endcase
          end
          P_ADR: begin
            ptr <= {ptr[ADDR_W-2:0], si_s};
            if (cnt == 4'd15) begin
              cnt <= '0;
              phase <= rdop ? P_RD : P_WR;
            end
          end
          P_RD, P_WR: if (byte_end) begin
            cnt <= '0;
            ptr <= ptr_nx;
            if (single) done <= 1'b1;
          end
          P_SRD: if (byte_end) cnt <= '0;
          P_SWR: if (byte_end) begin
            status <= {nb[7:6], 5'b0, nb[0]};
            phase <= P_IGN;
          end
          default: cnt <= '0;
        endcase
      end
      if (fall)
        case (phase)
          P_RD: so_q <= done ? 1'b0 : rdata[~cnt[2:0]];
          P_SRD: so_q <= status[~cnt[2:0]];
          default: so_q <= 1'b0;
        endcase
    end

  assign so = so_q;
  assign so_oe = ~cs_s & ~held & ~(hold_en & ~hd_s) & ((phase == P_RD) | (phase == P_SRD));

  a_r8_cs_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (phase == P_CMD) && (cnt == 4'd0));

  a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n || cs_s)
    (held && $past(held)) |-> ($stable(cnt) && $stable(ptr) && $stable(phase)));

  a_r9_hold_entry_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck_s));

  a_r4_burst_step: assert property (@(posedge clk) disable iff (!rst_n || cs_s)
    ((phase == P_RD || phase == P_WR) && $past(phase == P_RD || phase == P_WR)
     && mode == 2'b01 && ptr != $past(ptr)) |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n || cs_s)
    ((phase == P_RD || phase == P_WR) && $past(phase == P_RD || phase == P_WR)
     && mode == 2'b10) |-> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/sim_spi_sram_target.sv
module sim_spi_sram_target;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int PW = 3;
  localparam int N = 1 << AW;
  localparam int H = 6;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1;
  logic so, so_oe;
  int errors = 0, checks = 0;
  logic [7:0] model [N];

  spi_sram_target #(.ADDR_W(AW), .PAGE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r, output logic oe);
    si = b;
    wait_clk(H);
    r = so; oe = so_oe;
    sck = 1;
    wait_clk(H);
    sck = 0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    logic r, oe;
    oe_all = 1;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r, oe);
      rx[i] = r;
      oe_all &= oe;
    end
  endtask

  task automatic sel();
    cs_n = 0; wait_clk(H);
  endtask

  task automatic desel();
    wait_clk(H); cs_n = 1; wait_clk(H);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] rx; logic oe;
    sel();
    byte_x(op, rx, oe);
    byte_x(a[15:8], rx, oe);
    byte_x(a[7:0], rx, oe);
  endtask

  task automatic set_mode(input logic [7:0] v);
    logic [7:0] rx; logic oe;
    sel(); byte_x(8'h01, rx, oe); byte_x(v, rx, oe); desel();
  endtask

  task automatic get_mode(output logic [7:0] v, output logic oe);
    logic [7:0] rx;
    sel(); byte_x(8'h05, rx, oe); byte_x(8'h00, v, oe); desel();
  endtask

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 37 + k * 11 + 5) & 255);
  endfunction

  initial begin
    wait_clk(200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, rx; logic oe, r, o2;
    int a;
    wait_clk(3); rst_n = 1; wait_clk(3);
    check(so_oe == 0, "R1 reset oe", so_oe, 0);
    get_mode(v, oe);
    check(v == 8'h00, "R7 reset mode", v, 0);
    check(oe == 1, "R1 oe during status read", oe, 1);
    check(so_oe == 0, "R1 oe after deselect", so_oe, 0);

    set_mode(8'h40);
    get_mode(v, oe);
    check(v == 8'h40, "R7 burst mode readback", v, 8'h40);

    // R3 R4: burst write full array starting near the top, upper address bits set
    hdr(8'h02, 16'hFF80 | 16'h7C);
    for (int i = 0; i < N; i++) begin
      byte_x(pat(i, 0), rx, oe);
      model[(8'h7C + i) % N] = pat(i, 0);
    end
    desel();
    hdr(8'h03, 16'h0000);
    for (int i = 0; i < N + 2; i++) begin
      byte_x(8'h00, rx, oe);
      check(rx == model[i % N] && oe, "R4 burst read wrap", rx, model[i % N]);
    end
    desel();

    // R5: page mode write of 11 bytes from offset 6 of page 2
    set_mode(8'h80);
    hdr(8'h02, 16'h0016);
    for (int i = 0; i < 11; i++) begin
      a = (8'h16 & ~(8'h07)) | ((6 + i) % 8);
      byte_x(pat(i, 1), rx, oe);
      model[a] = pat(i, 1);
    end
    desel();
    hdr(8'h03, 16'h0013);
    for (int i = 0; i < 17; i++) begin
      a = 8'h10 | ((3 + i) % 8);
      byte_x(8'h00, rx, oe);
      check(rx == model[a], "R5 page read wrap", rx, model[a]);
    end
    desel();

    // R6: single-byte mode
    set_mode(8'h00);
    hdr(8'h02, 16'h0030);
    byte_x(8'hA5, rx, oe); byte_x(8'h5A, rx, oe); byte_x(8'h3C, rx, oe);
    model[8'h30] = 8'hA5;
    desel();
    hdr(8'h03, 16'h0030);
    byte_x(8'h00, rx, oe);
    check(rx == 8'hA5, "R6 single first byte", rx, 8'hA5);
    byte_x(8'h00, rx, oe);
    check(rx == 8'h00, "R6 single extra read zero", rx, 0);
    desel();
    hdr(8'h03, 16'h0031);
    byte_x(8'h00, rx, oe);
    check(rx == model[8'h31], "R6 extra write dropped", rx, model[8'h31]);
    desel();

    // R7: reserved bits forced to zero
    set_mode(8'hFF);
    get_mode(v, oe);
    check(v == 8'hC1, "R7 reserved bits masked", v, 8'hC1);
    set_mode(8'h40);

    // R2: unknown opcode ignores the rest
    sel();
    byte_x(8'hAB, rx, oe);
    byte_x(8'h02, rx, oe); byte_x(8'h00, rx, o2); byte_x(8'hFF, rx, o2);
    check(oe == 0 && o2 == 0, "R2 unknown opcode oe", oe, 0);
    desel();
    hdr(8'h03, 16'h0000);
    byte_x(8'h00, rx, oe);
    check(rx == model[0], "R2 unknown opcode no write", rx, model[0]);
    desel();
    get_mode(v, oe);
    check(v == 8'h40, "R2 mode unchanged", v, 8'h40);

    // R8: aborted write byte is not stored
    hdr(8'h02, 16'h0040);
    for (int i = 0; i < 5; i++) bit_x(1'b1, r, oe);
    desel();
    hdr(8'h03, 16'h0040);
    byte_x(8'h00, rx, oe);
    check(rx == model[8'h40], "R8 partial byte dropped", rx, model[8'h40]);
    desel();

    // R9: pause inside a read byte
    hdr(8'h03, 16'h0005);
    for (int i = 7; i >= 5; i--) begin
      bit_x(1'b0, r, oe);
      check(r == model[5][i], "R9 read before pause", r, model[5][i]);
    end
    hold_n = 0; wait_clk(H);
    check(so_oe == 0, "R9 oe off in pause", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      si = ~si; sck = 1; wait_clk(H); sck = 0; wait_clk(H);
    end
    check(so_oe == 0, "R9 oe off while clocks ignored", so_oe, 0);
    hold_n = 1; wait_clk(H);
    for (int i = 4; i >= 0; i--) begin
      bit_x(1'b0, r, oe);
      check(r == model[5][i] && oe, "R9 read resumes at bit", r, model[5][i]);
    end
    byte_x(8'h00, rx, oe);
    check(rx == model[6], "R9 read next byte after pause", rx, model[6]);
    desel();

    // R9: pause inside a write byte
    hdr(8'h02, 16'h0050);
    for (int i = 7; i >= 4; i--) bit_x(v[0] ^ 1'b1, r, oe);
    hold_n = 0; wait_clk(H);
    for (int i = 0; i < 4; i++) begin
      si = i[0]; sck = 1; wait_clk(H); sck = 0; wait_clk(H);
    end
    hold_n = 1; wait_clk(H);
    for (int i = 3; i >= 0; i--) bit_x(1'b0, r, oe);
    model[8'h50] = 8'hF0;
    desel();
    hdr(8'h03, 16'h0050);
    byte_x(8'h00, rx, oe);
    check(rx == 8'hF0, "R9 write across pause", rx, 8'hF0);
    byte_x(8'h00, rx, oe);
    check(rx == model[8'h51], "R9 neighbour untouched", rx, model[8'h51]);
    desel();

    // R10: pausing disabled
    set_mode(8'h41);
    hdr(8'h03, 16'h0020);
    hold_n = 0;
    byte_x(8'h00, rx, oe);
    check(rx == model[8'h20] && oe, "R10 hold ignored data", rx, model[8'h20]);
    check(so_oe == 1, "R10 oe kept with hold low", so_oe, 1);
    hold_n = 1;
    desel();
    check(so_oe == 0, "R1 oe off after deselect", so_oe, 0);

    // R11: SO sampled before every rise across a whole status byte
    get_mode(v, oe);
    check(v == 8'h41, "R11 status bits stable before rise", v, 8'h41);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule